// File: doc/BRIEF.md
# Byte-Serial Cipher Key Loader with Parity Check

This block collects a cipher key that a host delivers one byte per write over an 8-bit bus, and holds it in a key register that the host can write but never read. A key load starts in one of two ways. In software-programmed mode the host writes the control register with the start bit set. In pin-programmed mode a dedicated new-key input starts the load. Once a load has started, the block raises a key-request output until it has received every byte.

Each incoming byte carries an odd-parity bit, which is checked as the byte arrives. Any byte that fails the check sets a sticky error flag for the rest of that load. The flag reaches an active-low error output only while the parity-error-enable bit of the control register is set. After the last byte, the assembled 56-bit key goes to the cipher datapath together with a key-valid flag. A read aimed at the key register returns zero, so no stored key bit ever reaches the bus.

Top module: `keyload_top`

## Requirements
- R1: After reset, key_req and key_valid are low, kpe_n is high, the parity-error-enable bit reads back as 0 and key_out is all zeros.
- R2: With pin_prog low, a write to the control address (bus_addr = 1) with bit 6 set starts a load. On the following cycle key_req is high and key_valid is low.
- R3: While key_req is high, a write to bus_addr = 0 is taken as the next key byte. key_req stays high after the first seven bytes. It drops, and key_valid rises, in the cycle in which the eighth byte is taken.
- R4: Every key byte holds seven key bits in bits 7..1 and a parity bit in bit 0. key_out is the concatenation of bits 7..1 of the eight bytes, with the first byte in the most significant position.
- R5: A byte whose eight bits contain an even number of ones is a parity error. The error flag stays set until the load ends, even when later bytes are correct.
- R6: kpe_n is low exactly when the error flag is set and control bit 2 (parity-error enable) is 1. Changing bit 2 takes effect on kpe_n in the cycle after the write.
- R7: Starting a new load clears the error flag and drops key_valid.
- R8: With pin_prog high, a high on nk_pin starts a load, and the control start bit has no effect. With pin_prog low, nk_pin has no effect.
- R9: A read at bus_addr = 0 returns 8'h00 at all times. A read at bus_addr = 1 returns the control register, with only bit 2 able to be set.
- R10: A write to bus_addr = 0 while key_req is low leaves key_out, key_valid and the error flag unchanged.
- R11: Starting a load while another load is in progress restarts it from the first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | One-cycle host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 1 | 0 = key byte target, 1 = control register |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data (zero when not reading) |
| pin_prog | input | 1 | High selects pin-programmed start |
| nk_pin | input | 1 | New-key request used in pin-programmed mode |
| key_req | output | 1 | High while another key byte is wanted |
| key_valid | output | 1 | Full key is present on key_out |
| kpe_n | output | 1 | Active-low key parity error, gated by control bit 2 |
| key_out | output | 56 | Assembled key for the cipher datapath |

## Verification
Seeded random keys are loaded with a corrupt byte injected at a random position, or with no corruption, and with the error enable randomly set or cleared. This separates an error flag that tracks only the last byte from a sticky one, and it exposes any gating fault on kpe_n. Directed sequences cover the remaining cases: the request edge around the seventh and eighth bytes, a restart part-way through a load, stray key writes after completion, and each start source tried in its wrong mode. A byte order reversal shows up in key_out, and any leak of key bits shows up on a read of address 0.

// File: rtl/keyload_pkg.sv
package keyload_pkg;
   // host-visible address decode
   typedef enum logic {
      ADDR_KEY = 1'b0,
      ADDR_CTL = 1'b1
   } kl_addr_e;

   // control register bit positions
   localparam int CTL_PEN_BIT   = 2;
   localparam int CTL_START_BIT = 6;
endpackage

// File: rtl/keyload_parity.sv
module keyload_parity #(
   parameter int BYTE_W  = 8,
   parameter int PAR_POS = 0,
   parameter bit ODD     = 1'b1,
   localparam int DW     = BYTE_W - 1
) (
   input  logic [BYTE_W-1:0] byte_in,
   output logic [DW-1:0]     data_bits,
   output logic              par_bad
);
   if (PAR_POS < 0 || PAR_POS >= BYTE_W) begin : g_bad_pos
      $error("keyload_parity: PAR_POS out of range");
   end

   // strip the parity bit out of the byte
   for (genvar i = 0; i < BYTE_W; i++) begin : g_strip
      if (i < PAR_POS) begin : g_lo
         assign data_bits[i] = byte_in[i];
      end else if (i > PAR_POS) begin : g_hi
         assign data_bits[i-1] = byte_in[i];
      end
   end

   if (ODD) begin : g_odd
      assign par_bad = ~(^byte_in);
   end else begin : g_even
      assign par_bad = ^byte_in;
   end
endmodule

// File: rtl/keyload_seq.sv
module keyload_seq #(
   parameter int BYTES = 8,
   localparam int CNT_W = $clog2(BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             byte_wr,
   output logic             accept,
   output logic [CNT_W-1:0] slot,
   output logic             key_req,
   output logic             key_valid
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTES - 1);

   if (BYTES < 2) begin : g_bad_bytes
      $error("keyload_seq: BYTES must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             req_q, valid_q;

   assign accept    = byte_wr & req_q & ~start;
   assign slot      = cnt_q;
   assign key_req   = req_q;
   assign key_valid = valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         req_q   <= 1'b0;
         valid_q <= 1'b0;
      end else if (start) begin
         cnt_q   <= '0;
         req_q   <= 1'b1;
         valid_q <= 1'b0;
      end else if (accept) begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == LAST) begin
            req_q   <= 1'b0;
            valid_q <= 1'b1;
         end
      end
   end

   // R2 R11
   start_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (key_req && !key_valid));

   // R3
   last_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && slot == LAST) |=> (!key_req && key_valid));

   // R3
   mid_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && slot != LAST) |=> (key_req && !key_valid));
endmodule

// File: rtl/keyload_store.sv
module keyload_store #(
   parameter int BYTES = 8,
   parameter int DW    = 7,
   localparam int KEY_W = BYTES * DW,
   localparam int CNT_W = $clog2(BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic [CNT_W-1:0] slot,
   input  logic [DW-1:0]    data_bits,
   output logic [KEY_W-1:0] key_out
);
   for (genvar k = 0; k < BYTES; k++) begin : g_slot
      logic [DW-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q <= '0;
         else if (accept && slot == CNT_W'(k))
            slot_q <= data_bits;
      end
      // first byte lands in the most significant field
      assign key_out[KEY_W-1-k*DW -: DW] = slot_q;
   end

   // R10
   key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(key_out));
endmodule

// File: rtl/keyload_top.sv
module keyload_top
   import keyload_pkg::*;
#(
   parameter int BYTES   = 8,
   parameter int BYTE_W  = 8,
   parameter int PAR_POS = 0,
   parameter bit ODD     = 1'b1,
   localparam int DW     = BYTE_W - 1,
   localparam int KEY_W  = BYTES * DW,
   localparam int CNT_W  = $clog2(BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic              bus_addr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic              pin_prog,
   input  logic              nk_pin,
   output logic              key_req,
   output logic              key_valid,
   output logic              kpe_n,
   output logic [KEY_W-1:0]  key_out
);
   if (BYTE_W <= CTL_START_BIT) begin : g_bad_w
      $error("keyload_top: BYTE_W too narrow for control bits");
   end

   logic             ctl_wr, byte_wr, start, accept, par_bad;
   logic             pen_q, perr_q;
   logic [CNT_W-1:0] slot;
   logic [DW-1:0]    data_bits;

   assign ctl_wr  = bus_wr & (bus_addr == ADDR_CTL);
   assign byte_wr = bus_wr & (bus_addr == ADDR_KEY);
   assign start   = pin_prog ? nk_pin : (ctl_wr & bus_wdata[CTL_START_BIT]);

   keyload_parity #(.BYTE_W(BYTE_W), .PAR_POS(PAR_POS), .ODD(ODD)) u_par (
      .byte_in   (bus_wdata),
      .data_bits (data_bits),
      .par_bad   (par_bad)
   );

   keyload_seq #(.BYTES(BYTES)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .byte_wr   (byte_wr),
      .accept    (accept),
      .slot      (slot),
      .key_req   (key_req),
      .key_valid (key_valid)
   );

   keyload_store #(.BYTES(BYTES), .DW(DW)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .slot      (slot),
      .data_bits (data_bits),
      .key_out   (key_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pen_q <= 1'b0;
      else if (ctl_wr)
         pen_q <= bus_wdata[CTL_PEN_BIT];
   end

   // sticky over one load
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         perr_q <= 1'b0;
      else if (start)
         perr_q <= 1'b0;
      else if (accept && par_bad)
         perr_q <= 1'b1;
   end

   assign kpe_n = ~(perr_q & pen_q);

   // key register has no read path
   always_comb begin
      bus_rdata = '0;
      if (bus_rd && bus_addr == ADDR_CTL)
         bus_rdata[CTL_PEN_BIT] = pen_q;
   end

   // R6
   kpe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !kpe_n |-> pen_q);

   // R9
   no_key_leak_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_KEY) |-> (bus_rdata == '0));

   // R3
   valid_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(key_valid) |-> $past(key_req));

   // R7
   start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> kpe_n);
endmodule

// File: tb/keyload_top_test.sv
module keyload_top_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        pin_prog = 1'b0, nk_pin = 1'b0;
   logic        key_req, key_valid, kpe_n;
   logic [55:0] key_out;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   keyload_top uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_prog(pin_prog), .nk_pin(nk_pin), .key_req(key_req),
      .key_valid(key_valid), .kpe_n(kpe_n), .key_out(key_out)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] mk_byte(input logic [6:0] d, input bit corrupt);
      return {d, ~(^d) ^ corrupt};
   endfunction

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic a, output logic [7:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic pulse_nk;
      @(negedge clk);
      nk_pin = 1'b1;
      @(negedge clk);
      nk_pin = 1'b0;
   endtask

   // loads 8 bytes; bad_idx < 8 corrupts that byte
   task automatic load_key(input logic [55:0] k, input int bad_idx);
      for (int i = 0; i < 8; i++)
         wr(1'b0, mk_byte(k[55-7*i -: 7], i == bad_idx));
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0]  rv;
      logic [55:0] k;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 key_req", key_req, 0);
      check("R1 key_valid", key_valid, 0);
      check("R1 kpe_n", kpe_n, 1);
      check("R1 key_out", key_out, 0);
      rd(1'b1, rv);
      check("R1 ctl readback", rv, 0);

      // R2 command start, enable parity error output
      wr(1'b1, 8'h44);
      check("R2 key_req", key_req, 1);
      check("R2 key_valid", key_valid, 0);
      rd(1'b1, rv);
      check("R9 ctl readback", rv, 8'h04);

      // R3 R4 directed load
      k = 56'h12_3456_789A_BCDE;
      for (int i = 0; i < 7; i++) wr(1'b0, mk_byte(k[55-7*i -: 7], 1'b0));
      check("R3 req after 7", key_req, 1);
      check("R3 valid after 7", key_valid, 0);
      wr(1'b0, mk_byte(k[6:0], 1'b0));
      check("R3 req after 8", key_req, 0);
      check("R3 valid after 8", key_valid, 1);
      check("R4 key_out", key_out, k);
      check("R5 no error", kpe_n, 1);
      rd(1'b0, rv);
      check("R9 key read zero", rv, 0);

      // R10 stray writes after completion
      wr(1'b0, 8'hFF);
      wr(1'b0, 8'h01);
      check("R10 key_out held", key_out, k);
      check("R10 valid held", key_valid, 1);
      check("R10 no error", kpe_n, 1);

      // R5 R7 error sticky, then cleared by new start
      wr(1'b1, 8'h44);
      load_key(56'hAA_5555_AAAA_5555, 0);
      check("R5 sticky error", kpe_n, 0);
      wr(1'b1, 8'h00);
      check("R6 disabled", kpe_n, 1);
      wr(1'b1, 8'h04);
      check("R6 re-enabled", kpe_n, 0);
      wr(1'b1, 8'h44);
      check("R7 cleared", kpe_n, 1);
      check("R7 valid dropped", key_valid, 0);

      // R11 restart mid-load
      load_key(56'hFF_FFFF_FFFF_FFFF, 99);
      wr(1'b1, 8'h44);
      k = 56'h01_0203_0405_0607;
      for (int i = 0; i < 3; i++) wr(1'b0, mk_byte(8'h11, 1'b0));
      wr(1'b1, 8'h44);
      load_key(k, 99);
      check("R11 restarted key", key_out, k);
      check("R11 valid", key_valid, 1);

      // R8 pin mode
      pin_prog = 1'b1;
      wr(1'b1, 8'h44);
      check("R8 ctl start ignored", key_req, 0);
      check("R8 valid kept", key_valid, 1);
      pulse_nk;
      check("R8 nk starts", key_req, 1);
      k = 56'h7F_0011_2233_4455;
      load_key(k, 99);
      check("R8 key", key_out, k);
      pin_prog = 1'b0;
      pulse_nk;
      check("R8 nk ignored", key_req, 0);

      // random loads
      for (int n = 0; n < 40; n++) begin
         int bad;
         logic pen;
         k = {$urandom, $urandom} & 56'hFF_FFFF_FFFF_FFFF;
         bad = $urandom % 12;
         pen = $urandom % 2;
         wr(1'b1, {1'b0, 1'b1, 3'b000, pen, 2'b00});
         load_key(k, bad);
         check("R4 random key", key_out, k);
         check("R3 random valid", key_valid, 1);
         check("R6 random kpe_n", kpe_n, !(pen && bad < 8));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule